// File: doc/BRIEF.md
# Multi-Port GPIO Register Controller

This block is a memory-mapped controller for a bank of general-purpose pins. The pins are grouped into ports of eight, and the number of ports is set by a parameter (one to seven). A simple 32-bit register bus with a select, a write strobe, an address and write data gives software access. Each port has its own window of registers. Through them software sets the level each pin drives, its drive style and its pull-up, and reads back the level sampled on each pin.

Each pin has a 2-bit drive mode: input, push-pull, drive-low-only (open drain) or drive-high-only (open source). From that mode and the stored data bit, the block produces an output value, an output enable, a pull-up enable, and separate drive-high and drive-low enables for the pad. Incoming pin levels pass through a two-stage synchronizer before software can read them. A global word at address zero reports the port count and a version code, and holds two enable bits. Interrupt event capture belongs to a separate block, so its offsets read as zero here.

Top module: `gpb_ctrl_top`

## Requirements
- R1: After a synchronous active-low reset, every pin is in input mode (output enable 0, drive-high 0, drive-low 0), every pull-up is enabled, every data-out bit is 0, and both global enable bits are 0.
- R2: The word at address 0x00 reads as {16'b0, port count in bits 15:9, version code in bits 8:2, sync-select enable in bit 1, clock-request enable in bit 1:0's bit 0}. Only bits 1:0 are writable, and they appear on `ctrl_sync_sel` and `ctrl_clk_req`.
- R3: Port k's registers sit at base 0x30·k. Data-out is at +0x08 (bits 7:0), pin mode at +0x0C (bits 15:0), and pull-up disable at +0x10 (bits 7:0). Written values read back with the bits above the field returned as zero. Pin j of port k is bit 8·k+j of every pin vector.
- R4: The mode of pin j occupies bits 2j+1:2j of the mode register, encoded as 0 input, 1 push-pull, 2 drive-low-only, 3 drive-high-only. In input mode the output enable, output value, drive-high and drive-low are all 0.
- R5: In push-pull mode the output enable is 1 and the output value equals the data-out bit. Drive-high is set when that bit is 1, and drive-low when it is 0.
- R6: In drive-low-only mode the output value is 0, and the output enable (with drive-low) is 1 exactly when data-out is 0. Drive-high is never set.
- R7: In drive-high-only mode the output value is 1, and the output enable (with drive-high) is 1 exactly when data-out is 1. Drive-low is never set.
- R8: A 1 in bit j of the pull-up disable register clears `pin_pu_en` for pin j. A 0 sets it.
- R9: Offset +0x04 returns the pin levels through a two-flop synchronizer. A change on `pin_in` before clock edge N is visible after edge N+1 and not after edge N.
- R10: Reads of offsets with no register (including +0x00 of ports above 0, the interrupt offsets +0x14 to +0x20, and unaligned offsets) return 0. Writes to them change nothing.
- R11: Writes whose port index is at or above the port count are ignored, and reads from such an index return 0.
- R12: Drive-high and drive-low of a pin are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, 0 when not reading) |
| pin_in | input | NUM_PORTS*8 | Raw pin levels |
| pin_out | output | NUM_PORTS*8 | Output value per pin |
| pin_oe | output | NUM_PORTS*8 | Output enable per pin |
| pin_pu_en | output | NUM_PORTS*8 | Pull-up enable per pin |
| pad_drv_hi | output | NUM_PORTS*8 | Pad drives high |
| pad_drv_lo | output | NUM_PORTS*8 | Pad drives low |
| ctrl_sync_sel | output | 1 | Global sync-select enable bit |
| ctrl_clk_req | output | 1 | Global clock-request enable bit |

## Verification
A table walks a single pin through every drive mode with both data-out levels and with the pull-up both on and off. This separates the three output styles by their enable and value pairs, and shows that input mode is isolated from the data bit. Full-port writes of all ones, and a single pin placed in a higher port, confirm the stride, the bit positions and the read-back masks. Directed sequences time the synchronizer to the exact edge. They also show that unused offsets, a non-zero port's offset zero and an out-of-range port index neither store data nor disturb their neighbours.

// File: rtl/gpb_pkg.sv
// Shared definitions for the GPIO bank controller.
// Assumes byte addressing with 32-bit word registers.
package gpb_pkg;
    localparam int PORT_PINS    = 8;
    localparam int MAX_PORTS    = 7;
    localparam int STRIDE_BYTES = 48;

    localparam logic [5:0] OFS_CTRL  = 6'h00;
    localparam logic [5:0] OFS_LEVEL = 6'h04;
    localparam logic [5:0] OFS_DOUT  = 6'h08;
    localparam logic [5:0] OFS_MODE  = 6'h0C;
    localparam logic [5:0] OFS_PUDIS = 6'h10;

    typedef enum logic [1:0] {
        DRV_INPUT       = 2'd0,
        DRV_PUSHPULL    = 2'd1,
        DRV_SINK_ONLY   = 2'd2,
        DRV_SOURCE_ONLY = 2'd3
    } drv_mode_e;
endpackage

// File: rtl/gpb_pin_drive.sv
// Per-pin pad control: turns a drive mode, data bit and pull-up disable
// bit into output value, output enable and pad drive enables.
// Assumes the mode and data come straight from registered state.
module gpb_pin_drive
    import gpb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  drv_mode_e mode,
    input  logic      dout,
    input  logic      pu_dis,
    output logic      out,
    output logic      oe,
    output logic      drv_hi,
    output logic      drv_lo,
    output logic      pu_en
);
    // Decode mode and data into output value and enable.
    always_comb begin
        out = 1'b0;
        oe  = 1'b0;
        case (mode)
            DRV_PUSHPULL: begin
                out = dout;
                oe  = 1'b1;
            end
            DRV_SINK_ONLY: begin
                out = 1'b0;
                oe  = ~dout;
            end
            DRV_SOURCE_ONLY: begin
                out = 1'b1;
                oe  = dout;
            end
            default: begin
                out = 1'b0;
                oe  = 1'b0;
            end
        endcase
    end

    assign drv_hi = oe & out;
    assign drv_lo = oe & ~out;
    assign pu_en  = ~pu_dis;

    p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_hi && drv_lo));
    p_in_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DRV_INPUT) |-> (!drv_hi && !drv_lo));
    p_sink_no_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DRV_SINK_ONLY) |-> !drv_hi);
    p_src_no_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DRV_SOURCE_ONLY) |-> !drv_lo);
endmodule

// File: rtl/gpb_port_bank.sv
// One 8-pin port: data-out, mode and pull-up disable registers, a two-flop
// input synchronizer and eight pin drivers. The caller decodes the port
// index; this module sees only the in-window offset and a write strobe.
module gpb_port_bank
    import gpb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [5:0]           ofs,
    input  logic [31:0]          wdata,
    input  logic [PORT_PINS-1:0] pin_in,
    output logic [31:0]          rd_data,
    output logic [PORT_PINS-1:0] pin_out,
    output logic [PORT_PINS-1:0] pin_oe,
    output logic [PORT_PINS-1:0] pin_pu_en,
    output logic [PORT_PINS-1:0] drv_hi,
    output logic [PORT_PINS-1:0] drv_lo
);
    localparam int MODE_W = 2 * PORT_PINS;

    logic [PORT_PINS-1:0] dout_q;
    logic [MODE_W-1:0]    mode_q;
    logic [PORT_PINS-1:0] pudis_q;
    logic [PORT_PINS-1:0] sync1_q;
    logic [PORT_PINS-1:0] lvl_q;
    logic [1:0]           warm_q;

    // Configuration registers, written by offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q  <= '0;
            mode_q  <= '0;
            pudis_q <= '0;
        end else if (wr_en) begin
            case (ofs)
                OFS_DOUT:  dout_q  <= wdata[PORT_PINS-1:0];
                OFS_MODE:  mode_q  <= wdata[MODE_W-1:0];
                OFS_PUDIS: pudis_q <= wdata[PORT_PINS-1:0];
                default: ;
            endcase
        end
    end

    // Two-stage synchronizer for the incoming pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= '0;
            lvl_q   <= '0;
        end else begin
            sync1_q <= pin_in;
            lvl_q   <= sync1_q;
        end
    end

    // Cycles since reset, saturating; qualifies the latency check.
    always_ff @(posedge clk) begin
        if (!rst_n)               warm_q <= 2'd0;
        else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
    end

    // Read-back mux; unknown offsets return zero.
    always_comb begin
        case (ofs)
            OFS_LEVEL: rd_data = {{(32-PORT_PINS){1'b0}}, lvl_q};
            OFS_DOUT:  rd_data = {{(32-PORT_PINS){1'b0}}, dout_q};
            OFS_MODE:  rd_data = {{(32-MODE_W){1'b0}}, mode_q};
            OFS_PUDIS: rd_data = {{(32-PORT_PINS){1'b0}}, pudis_q};
            default:   rd_data = 32'd0;
        endcase
    end

    for (genvar g = 0; g < PORT_PINS; g++) begin : g_pin
        gpb_pin_drive u_pin (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode   (drv_mode_e'(mode_q[2*g +: 2])),
            .dout   (dout_q[g]),
            .pu_dis (pudis_q[g]),
            .out    (pin_out[g]),
            .oe     (pin_oe[g]),
            .drv_hi (drv_hi[g]),
            .drv_lo (drv_lo[g]),
            .pu_en  (pin_pu_en[g])
        );
    end

    p_dout_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ofs == OFS_DOUT) |=> (dout_q == $past(wdata[PORT_PINS-1:0])));
    p_sync_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (lvl_q == $past(pin_in, 2)));
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> ($stable(dout_q) && $stable(mode_q) && $stable(pudis_q)));
endmodule

// File: rtl/gpb_ctrl_top.sv
// GPIO bank controller top: decodes the byte address into a port index
// and in-window offset, holds the global control word and replicates the
// port banks. Assumes NUM_PORTS in 1..7 and ADDR_W wide enough for them.
module gpb_ctrl_top
    import gpb_pkg::*;
#(
    parameter int         NUM_PORTS  = 3,
    parameter int         ADDR_W     = 12,
    parameter logic [6:0] VERSION_ID = 7'h0B
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_sel,
    input  logic                           bus_wr,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [31:0]                    bus_wdata,
    output logic [31:0]                    bus_rdata,
    input  logic [NUM_PORTS*PORT_PINS-1:0] pin_in,
    output logic [NUM_PORTS*PORT_PINS-1:0] pin_out,
    output logic [NUM_PORTS*PORT_PINS-1:0] pin_oe,
    output logic [NUM_PORTS*PORT_PINS-1:0] pin_pu_en,
    output logic [NUM_PORTS*PORT_PINS-1:0] pad_drv_hi,
    output logic [NUM_PORTS*PORT_PINS-1:0] pad_drv_lo,
    output logic                           ctrl_sync_sel,
    output logic                           ctrl_clk_req
);
    localparam logic [ADDR_W-1:0] STRIDE_A = ADDR_W'(STRIDE_BYTES);
    localparam logic [ADDR_W-1:0] NPORTS_A = ADDR_W'(NUM_PORTS);

    logic [ADDR_W-1:0]    port_idx;
    logic [5:0]           ofs;
    logic                 is_global;
    logic                 ctrl_wr;
    logic [1:0]           ctrl_q;
    logic [NUM_PORTS-1:0] port_wr;
    logic [31:0]          bank_rd [NUM_PORTS];
    logic [31:0]          rd_mux;

    assign port_idx  = bus_addr / STRIDE_A;
    assign ofs       = 6'(bus_addr % STRIDE_A);
    assign is_global = (port_idx == '0) && (ofs == OFS_CTRL);
    assign ctrl_wr   = bus_sel && bus_wr && is_global;

    // Global enable bits; the rest of the word is read-only.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= 2'b00;
        else if (ctrl_wr) ctrl_q <= bus_wdata[1:0];
    end

    assign ctrl_clk_req  = ctrl_q[0];
    assign ctrl_sync_sel = ctrl_q[1];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign port_wr[p] = bus_sel && bus_wr && (port_idx == ADDR_W'(p));

        gpb_port_bank u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (port_wr[p]),
            .ofs       (ofs),
            .wdata     (bus_wdata),
            .pin_in    (pin_in[p*PORT_PINS +: PORT_PINS]),
            .rd_data   (bank_rd[p]),
            .pin_out   (pin_out[p*PORT_PINS +: PORT_PINS]),
            .pin_oe    (pin_oe[p*PORT_PINS +: PORT_PINS]),
            .pin_pu_en (pin_pu_en[p*PORT_PINS +: PORT_PINS]),
            .drv_hi    (pad_drv_hi[p*PORT_PINS +: PORT_PINS]),
            .drv_lo    (pad_drv_lo[p*PORT_PINS +: PORT_PINS])
        );
    end

    // Read selection: global word, the addressed bank, or zero.
    always_comb begin
        rd_mux = 32'd0;
        if (is_global) begin
            rd_mux = {16'd0, 7'(NUM_PORTS), VERSION_ID, ctrl_q};
        end else if (port_idx < NPORTS_A) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (port_idx == ADDR_W'(p)) rd_mux = bank_rd[p];
            end
        end
    end

    assign bus_rdata = (bus_sel && !bus_wr) ? rd_mux : 32'd0;

    p_one_port_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_wr));
    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(ctrl_q));
    p_ctrl_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (ctrl_clk_req == $past(bus_wdata[0])));
endmodule

// File: tb/tb_gpb_ctrl_top.sv
`timescale 1ns/1ps
module tb_gpb_ctrl_top;
    localparam int NP = 3;
    localparam int NW = NP * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NW-1:0] pin_in = '0;
    logic [NW-1:0] pin_out, pin_oe, pin_pu_en, pad_drv_hi, pad_drv_lo;
    logic          ctrl_sync_sel, ctrl_clk_req;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    gpb_ctrl_top #(.NUM_PORTS(NP), .ADDR_W(12), .VERSION_ID(7'h0B)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_pu_en(pin_pu_en), .pad_drv_hi(pad_drv_hi), .pad_drv_lo(pad_drv_lo),
        .ctrl_sync_sel(ctrl_sync_sel), .ctrl_clk_req(ctrl_clk_req)
    );

    // Entry: {mode[1:0], dout, pudis, oe, out, hi, lo, pu}
    localparam logic [8:0] VEC [8] = '{
        {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
        {2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        {2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
        {2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        {2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'd0: return "R4";
            2'd1: return "R5";
            2'd2: return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1: reset state at the ports and in registers
        check("R1 oe", 32'(pin_oe), 32'd0);
        check("R1 drive", 32'(pad_drv_hi | pad_drv_lo), 32'd0);
        check("R1 pullup", 32'(pin_pu_en), 32'hFF_FFFF);
        check("R1 ctrl", {30'd0, ctrl_sync_sel, ctrl_clk_req}, 32'd0);
        bread(12'h008, rd); check("R1 dout", rd, 32'd0);
        bread(12'h03C, rd); check("R1 mode", rd, 32'd0);

        // R2: global word: 3 ports -> 0x600, version 0x0B -> 0x2C
        bread(12'h000, rd); check("R2 id", rd, 32'h0000_062C);
        bwrite(12'h000, 32'hFFFF_FFFF);
        bread(12'h000, rd); check("R2 id+en", rd, 32'h0000_062F);
        check("R2 pins", {30'd0, ctrl_sync_sel, ctrl_clk_req}, 32'd3);
        bwrite(12'h000, 32'h0000_0001);
        check("R2 partial", {30'd0, ctrl_sync_sel, ctrl_clk_req}, 32'd1);

        // R4 R5 R6 R7 R8: table walk on port 1 pin 3 (vector bit 11)
        for (int i = 0; i < 8; i++) begin
            logic [8:0] v;
            v = VEC[i];
            bwrite(12'h03C, 32'(v[8:7]) << 6);
            bwrite(12'h038, 32'(v[6]) << 3);
            bwrite(12'h040, 32'(v[5]) << 3);
            #1;
            check(mode_tag(v[8:7]), {28'd0, pin_oe[11], pin_out[11], pad_drv_hi[11], pad_drv_lo[11]},
                  {28'd0, v[4:1]});
            check("R8", 32'(pin_pu_en[11]), 32'(v[0]));
        end

        // R3: read-back masks and full-port field placement on port 0
        bwrite(12'h008, 32'hFFFF_FFFF);
        bwrite(12'h00C, 32'hFFFF_FFFF);
        bwrite(12'h010, 32'hFFFF_FFFF);
        bread(12'h008, rd); check("R3 dout mask", rd, 32'h0000_00FF);
        bread(12'h00C, rd); check("R3 mode mask", rd, 32'h0000_FFFF);
        bread(12'h010, rd); check("R3 pudis mask", rd, 32'h0000_00FF);
        check("R3 port0 pins", {16'd0, pad_drv_hi[7:0], pin_pu_en[7:0]}, 32'h0000_FF00);

        // R3: port 2 pin 5 push-pull high -> vector bit 21 only in port 2
        bwrite(12'h06C, 32'h0000_0400);
        bwrite(12'h068, 32'h0000_0020);
        #1;
        check("R3 stride", 32'(pad_drv_hi[23:16]), 32'h20);

        // R9: synchronizer latency on port 2 pin 1 (vector bit 17, addr 0x64)
        @(negedge clk);
        pin_in[17] = 1'b1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h064;
        @(posedge clk); #1;
        check("R9 one edge", bus_rdata, 32'h0);
        @(posedge clk); #1;
        check("R9 two edges", bus_rdata, 32'h2);
        bus_sel = 1'b0;

        // R10: unused offsets read zero and hold nothing
        bwrite(12'h044, 32'hFFFF_FFFF);
        bread(12'h044, rd); check("R10 irq ofs", rd, 32'd0);
        bwrite(12'h030, 32'h0000_0002);
        bread(12'h030, rd); check("R10 port1 ofs0", rd, 32'd0);
        check("R10 ctrl intact", {30'd0, ctrl_sync_sel, ctrl_clk_req}, 32'd1);
        bwrite(12'h039, 32'hFFFF_FFFF);
        bread(12'h038, rd); check("R10 unaligned", rd, 32'd0);

        // R11: port index 3 is out of range
        bwrite(12'h098, 32'hFFFF_FFFF);
        bwrite(12'h09C, 32'hFFFF_FFFF);
        bread(12'h098, rd); check("R11 read", rd, 32'd0);
        bread(12'h068, rd); check("R11 port2 intact", rd, 32'h20);
        bread(12'h038, rd); check("R11 port1 intact", rd, 32'd0);

        // R12: no pin drives both ways after all the above
        check("R12", 32'(pad_drv_hi & pad_drv_lo), 32'd0);

        // R1: reset again clears configuration
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1; rst_n = 1'b1;
        #1;
        check("R1 re-reset", 32'(pin_oe), 32'd0);
        check("R1 re-reset en", 32'(ctrl_clk_req), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule